// File: doc/BRIEF.md
# SD Card Clock Divider Controller

This block turns a fixed base clock (about 50 MHz) into the clock for an SD card. The card frequency comes from an 8-bit divider, so the output rate is the base rate divided by the divider value plus one. When software asks for a frequency, the block computes the divider with an iterative engine. It then applies two policies on top of that stored value:

- After a power-on event, a forced slow rate holds until the first bulk transfer finishes without error.
- While the platform raises its slow flag, the divider is scaled by a fixed ratio.

The applied divider is written into the low byte of a 16-bit register. Another function owns the upper byte of that register.

The block also gates the card clock. When idle clocking is not allowed, the clock stops after each request completes and restarts when the next request begins. A glitch-free counter generator makes the card clock, and it adopts a new divider or run state only at the boundary of an output period.

Top module: `sdclk_ctrl`

## Requirements
- R1: After reset the shared register reads 0x00FF, the stored divider reads 16, the clock-run flag is 0 and the card clock is low.
- R2: A nonzero frequency request F sets the stored divider to the smallest d in 0..254 with floor(BASE/(d+1)) <= F, or to 255 when no such d exists. That is, d = min(floor(BASE/(F+1)), 255), which makes BASE/256 the slowest reachable rate.
- R3: A zero frequency request sets the stored divider to 0xFF and leaves the shared low byte unchanged. It stops the clock only when idle clocking is off and no post-power override is active; otherwise the run flag keeps its value.
- R4: A power-on pulse starts the post-power override and runs the clock. While the override is active, every divider load applies min(BASE/POST_HZ, 255), which is 50 by default, whatever the slow flag says. A completed request does not stop the clock during the override.
- R5: With no override active and the slow flag high, a divider load applies min(stored*SLOW_RATIO, 255); the default ratio is 8.
- R6: A request-done pulse stops the clock when idle clocking is off and no override is active. When idle clocking is on, the clock keeps running.
- R7: A request-start pulse writes the applied divider into share_reg[7:0] and runs the clock, on the next clock edge.
- R8: A high-byte write changes only share_reg[15:8]. Divider loads change only share_reg[7:0] and keep the upper byte.
- R9: While running with applied divider d >= 1, card_clk has a period of d+1 base cycles and stays high for floor(d/2)+1 of them. When the clock is stopped, card_clk is held low.
- R10: A new divider takes effect only at the end of the current card_clk period.
- R11: When bulk_ok and req_done arrive in the same cycle, the override is cleared first. The completion is then judged without it, so with idle clocking off the clock stops.
- R12: When the search for a nonzero request completes, the applied divider is loaded into share_reg[7:0]. The run flag becomes idle_clk_en OR the override.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| freq_wr | input | 1 | Pulse: start a divider search for freq_hz |
| freq_hz | input | 32 | Requested card frequency in Hz (0 = stop) |
| slow_req | input | 1 | Platform slow flag (level) |
| idle_clk_en | input | 1 | Allow the card clock to run while idle (level) |
| power_on | input | 1 | Pulse: card powered on, start post-power override |
| bulk_ok | input | 1 | Pulse: bulk transfer completed without error |
| req_start | input | 1 | Pulse: request begins |
| req_done | input | 1 | Pulse: request finished |
| hi_wr | input | 1 | Pulse: write upper byte of the shared register |
| hi_data | input | 8 | Data for the upper byte |
| share_reg | output | 16 | Shared register; low byte is the applied divider |
| stored_div | output | 8 | Divider kept from the last frequency request |
| search_busy | output | 1 | Divider search in progress |
| clk_run | output | 1 | Card clock enable requested |
| card_clk | output | 1 | Divided card clock |

## Verification
Two functions of the block can land in the same cycle: clearing the post-power override on a good bulk transfer, and the idle gating that follows a completed request. The bench provokes this by raising bulk_ok and req_done on the same edge with idle clocking off and the override active. It judges the outcome at the ports: clk_run must read 0 at the next edge, and the following request-start must load the plain stored divider instead of the post-power value. A second overlap is a divider change that arrives in the middle of a card clock period. The bench counts the high phase of that period against the old divider and measures the next period against the new one.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

  typedef struct packed {
    logic power_on;
    logic bulk_ok;
    logic req_start;
    logic req_done;
  } sdclk_ev_t;

  function automatic int unsigned clamp_div(input int unsigned v,
                                            input int unsigned maxv);
    return (v > maxv) ? maxv : v;
  endfunction

  // Divider that is actually programmed, given the stored one and policy.
  function automatic int unsigned pick_div(input int unsigned stored,
                                           input logic        force_slow,
                                           input logic        slow,
                                           input int unsigned post_div,
                                           input int unsigned ratio,
                                           input int unsigned maxv);
    if (force_slow)
      return clamp_div(post_div, maxv);
    else if (slow)
      return clamp_div(stored * ratio, maxv);
    else
      return clamp_div(stored, maxv);
  endfunction

endpackage

// File: rtl/sdclk_div_search.sv
module sdclk_div_search #(
  parameter int unsigned BASE_HZ = 50_000_000,
  parameter int unsigned FREQ_W  = 32,
  parameter int unsigned DIV_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [FREQ_W-1:0] freq,
  output logic              busy,
  output logic              done,
  output logic              zero,
  output logic [DIV_W-1:0]  div_res
);
  localparam int unsigned QW      = $clog2(BASE_HZ + 1);
  localparam int unsigned RW      = FREQ_W + 1;
  localparam int unsigned CW      = $clog2(QW + 1);
  localparam int unsigned DIV_MAX = (1 << DIV_W) - 1;

  logic [QW-1:0] num_q;
  logic [RW-1:0] rem_q;
  logic [RW-1:0] den_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q, zero_q;
  logic [RW:0]   trial;
  logic          take;

  // restoring division of BASE_HZ by (freq+1), one quotient bit per cycle
  always_comb begin
    trial = {rem_q, num_q[QW-1]};
    take  = (trial >= {1'b0, den_q});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      zero_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        if (freq == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          zero_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          zero_q <= 1'b0;
          num_q  <= QW'(BASE_HZ);
          rem_q  <= '0;
          den_q  <= RW'(freq) + RW'(1);
          cnt_q  <= CW'(QW);
        end
      end else if (busy_q) begin
        rem_q <= take ? RW'(trial - {1'b0, den_q}) : trial[RW-1:0];
        num_q <= {num_q[QW-2:0], take};
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign zero    = zero_q;
  assign div_res = zero_q ? DIV_W'(DIV_MAX)
                          : DIV_W'(sdclk_pkg::clamp_div(32'(num_q), DIV_MAX));

  // R2: the search always reports its result as it leaves the busy state
  p_busy_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);

endmodule

// File: rtl/sdclk_policy.sv
module sdclk_policy #(
  parameter int unsigned DIV_W      = 8,
  parameter int unsigned SHARE_W    = 16,
  parameter int unsigned POST_DIV   = 50,
  parameter int unsigned SLOW_RATIO = 8,
  parameter int unsigned RST_DIV    = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  sdclk_pkg::sdclk_ev_t      ev,
  input  logic                      slow_req,
  input  logic                      idle_clk_en,
  input  logic                      srch_done,
  input  logic                      srch_zero,
  input  logic [DIV_W-1:0]          srch_div,
  input  logic                      hi_wr,
  input  logic [SHARE_W-DIV_W-1:0]  hi_data,
  output logic [SHARE_W-1:0]        share_reg,
  output logic [DIV_W-1:0]          stored_div,
  output logic                      clk_run
);
  localparam int unsigned DIV_MAX    = (1 << DIV_W) - 1;
  localparam int unsigned POST_APPLY = sdclk_pkg::clamp_div(POST_DIV, DIV_MAX);

  logic [SHARE_W-1:0] share_q, share_n;
  logic [DIV_W-1:0]   stored_q, stored_n, apply_div;
  logic               run_q, run_n;
  logic               force_q, force_n;
  logic               keep_clk, load_div;

  always_comb begin
    force_n  = ev.power_on ? 1'b1 : (ev.bulk_ok ? 1'b0 : force_q);
    stored_n = srch_done ? srch_div : stored_q;
    keep_clk = idle_clk_en | force_n;

    run_n = run_q;
    if (srch_done) begin
      if (!srch_zero)     run_n = keep_clk;
      else if (!keep_clk) run_n = 1'b0;
    end
    if (ev.req_done && !keep_clk) run_n = 1'b0;
    if (ev.req_start || ev.power_on) run_n = 1'b1;

    apply_div = DIV_W'(sdclk_pkg::pick_div(32'(stored_n), force_n, slow_req,
                                           POST_DIV, SLOW_RATIO, DIV_MAX));
    load_div  = ev.req_start | ev.power_on | (srch_done & ~srch_zero);

    share_n = share_q;
    if (load_div) share_n[DIV_W-1:0]       = apply_div;
    if (hi_wr)    share_n[SHARE_W-1:DIV_W] = hi_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      share_q  <= SHARE_W'(DIV_MAX);
      stored_q <= DIV_W'(RST_DIV);
      run_q    <= 1'b0;
      force_q  <= 1'b0;
    end else begin
      share_q  <= share_n;
      stored_q <= stored_n;
      run_q    <= run_n;
      force_q  <= force_n;
    end
  end

  assign share_reg  = share_q;
  assign stored_div = stored_q;
  assign clk_run    = run_q;

  // R8: the upper byte belongs to the other function
  p_upper_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_wr |=> $stable(share_q[SHARE_W-1:DIV_W]));

  // R4: override dominates every divider load while it is in force
  p_force_div_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (force_q && !ev.bulk_ok && (ev.req_start || ev.power_on))
      |=> share_q[DIV_W-1:0] == DIV_W'(POST_APPLY));

  // R6: idle gating after a completed request
  p_gate_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.req_done && !ev.req_start && !ev.power_on && !srch_done &&
     !idle_clk_en && !force_q) |=> !run_q);

  // R11: a good bulk transfer in the same cycle clears the override first
  p_same_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.req_done && ev.bulk_ok && !ev.req_start && !ev.power_on &&
     !srch_done && !idle_clk_en) |=> (!run_q && !force_q));

  // R7: a starting request always runs the clock
  p_start_runs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev.req_start |=> run_q);

  // R3: a zero request parks the stored divider at its maximum
  p_zero_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_done && srch_zero) |=> stored_q == DIV_W'(DIV_MAX));

endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             card_clk
);
  logic [DIV_W-1:0] cnt_q, cnt_n;
  logic [DIV_W-1:0] act_div_q, act_div_n;
  logic             act_run_q, act_run_n;
  logic             clk_q, clk_n;
  logic             wrap;

  // period boundary: terminal count, or any cycle while stopped
  always_comb begin
    wrap      = !act_run_q || (cnt_q == act_div_q);
    cnt_n     = wrap ? '0  : cnt_q + 1'b1;
    act_div_n = wrap ? div : act_div_q;
    act_run_n = wrap ? run : act_run_q;
    clk_n     = act_run_n && (cnt_n <= (act_div_n >> 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      act_div_q <= '0;
      act_run_q <= 1'b0;
      clk_q     <= 1'b0;
    end else begin
      cnt_q     <= cnt_n;
      act_div_q <= act_div_n;
      act_run_q <= act_run_n;
      clk_q     <= clk_n;
    end
  end

  assign card_clk = clk_q;

  // R10: the active divider changes only across a period boundary
  p_div_boundary_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_div_q) |-> $past(wrap));

  // R9: a stopped generator drives the card clock low
  p_stopped_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_run_q && !run) |=> !card_clk);

  // R9: counter stays inside the active period
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    act_run_q |-> cnt_q <= act_div_q);

endmodule

// File: rtl/sdclk_ctrl.sv
module sdclk_ctrl #(
  parameter int unsigned BASE_HZ    = 50_000_000,
  parameter int unsigned POST_HZ    = 1_000_000,
  parameter int unsigned SLOW_RATIO = 8,
  parameter int unsigned FREQ_W     = 32,
  parameter int unsigned DIV_W      = 8,
  parameter int unsigned SHARE_W    = 16,
  parameter int unsigned RST_DIV    = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     freq_wr,
  input  logic [FREQ_W-1:0]        freq_hz,
  input  logic                     slow_req,
  input  logic                     idle_clk_en,
  input  logic                     power_on,
  input  logic                     bulk_ok,
  input  logic                     req_start,
  input  logic                     req_done,
  input  logic                     hi_wr,
  input  logic [SHARE_W-DIV_W-1:0] hi_data,
  output logic [SHARE_W-1:0]       share_reg,
  output logic [DIV_W-1:0]         stored_div,
  output logic                     search_busy,
  output logic                     clk_run,
  output logic                     card_clk
);
  localparam int unsigned POST_DIV = BASE_HZ / POST_HZ;

  sdclk_pkg::sdclk_ev_t ev;
  logic                 srch_done, srch_zero;
  logic [DIV_W-1:0]     srch_div;

  assign ev = '{power_on: power_on, bulk_ok: bulk_ok,
                req_start: req_start, req_done: req_done};

  sdclk_div_search #(
    .BASE_HZ (BASE_HZ),
    .FREQ_W  (FREQ_W),
    .DIV_W   (DIV_W)
  ) u_search (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (freq_wr),
    .freq    (freq_hz),
    .busy    (search_busy),
    .done    (srch_done),
    .zero    (srch_zero),
    .div_res (srch_div)
  );

  sdclk_policy #(
    .DIV_W      (DIV_W),
    .SHARE_W    (SHARE_W),
    .POST_DIV   (POST_DIV),
    .SLOW_RATIO (SLOW_RATIO),
    .RST_DIV    (RST_DIV)
  ) u_policy (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev          (ev),
    .slow_req    (slow_req),
    .idle_clk_en (idle_clk_en),
    .srch_done   (srch_done),
    .srch_zero   (srch_zero),
    .srch_div    (srch_div),
    .hi_wr       (hi_wr),
    .hi_data     (hi_data),
    .share_reg   (share_reg),
    .stored_div  (stored_div),
    .clk_run     (clk_run)
  );

  sdclk_gen #(
    .DIV_W (DIV_W)
  ) u_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (clk_run),
    .div      (share_reg[DIV_W-1:0]),
    .card_clk (card_clk)
  );

endmodule

// File: tb/sdclk_ctrl_tb_top.sv
`timescale 1ns/1ps
module sdclk_ctrl_tb_top;
  localparam longint BASE = 50_000_000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        freq_wr = 1'b0;
  logic [31:0] freq_hz = '0;
  logic        slow_req = 1'b0;
  logic        idle_clk_en = 1'b0;
  logic        power_on = 1'b0;
  logic        bulk_ok = 1'b0;
  logic        req_start = 1'b0;
  logic        req_done = 1'b0;
  logic        hi_wr = 1'b0;
  logic [7:0]  hi_data = '0;
  logic [15:0] share_reg;
  logic [7:0]  stored_div;
  logic        search_busy, clk_run, card_clk;

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk = ~clk;

  sdclk_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .freq_wr(freq_wr), .freq_hz(freq_hz),
    .slow_req(slow_req), .idle_clk_en(idle_clk_en), .power_on(power_on),
    .bulk_ok(bulk_ok), .req_start(req_start), .req_done(req_done),
    .hi_wr(hi_wr), .hi_data(hi_data), .share_reg(share_reg),
    .stored_div(stored_div), .search_busy(search_busy),
    .clk_run(clk_run), .card_clk(card_clk)
  );

  // expected divider: first d whose output rate does not exceed the request
  function automatic int exp_search(input longint f);
    if (f == 0) return 255;
    for (int d = 0; d < 255; d++)
      if (BASE / (d + 1) <= f) return d;
    return 255;
  endfunction

  function automatic int exp_apply(input int stored, input bit frc, input bit slw);
    int v;
    v = frc ? int'(BASE / 1_000_000) : (slw ? stored * 8 : stored);
    return (v > 255) ? 255 : v;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: power_on = 1'b1;
      1: req_start = 1'b1;
      2: req_done = 1'b1;
      3: begin req_done = 1'b1; bulk_ok = 1'b1; end
      default: ;
    endcase
    @(negedge clk);
    power_on = 1'b0; req_start = 1'b0; req_done = 1'b0; bulk_ok = 1'b0;
  endtask

  task automatic write_freq(input logic [31:0] f);
    @(negedge clk);
    freq_hz = f; freq_wr = 1'b1;
    @(negedge clk);
    freq_wr = 1'b0;
    while (search_busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic find_rise();
    logic prev;
    int g;
    prev = card_clk; g = 0;
    @(negedge clk);
    while (!(prev == 1'b0 && card_clk == 1'b1) && g < 3000) begin
      prev = card_clk; @(negedge clk); g++;
    end
  endtask

  task automatic measure(output int per, output int hi);
    logic prev;
    find_rise();
    per = 0; hi = 0;
    do begin
      if (card_clk) hi++;
      per++;
      prev = card_clk;
      @(negedge clk);
    end while (!(prev == 1'b0 && card_clk == 1'b1) && per < 3000);
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int per, hi, sd, prev_run;
    logic [31:0] f;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 share_reg", share_reg, 16'h00FF);
    check("R1 stored_div", stored_div, 16);
    check("R1 clk_run", clk_run, 0);
    check("R1 card_clk", card_clk, 0);

    // R8: upper byte write leaves the divider byte alone
    @(negedge clk); hi_wr = 1'b1; hi_data = 8'hA5;
    @(negedge clk); hi_wr = 1'b0;
    check("R8 upper write", share_reg, 16'hA5FF);

    // R4: post-power override
    pulse(0);
    check("R4 power-on div", share_reg[7:0], 50);
    check("R4 power-on run", clk_run, 1);
    pulse(1);
    check("R4 start div", share_reg[7:0], 50);
    pulse(2);
    check("R4 done keeps clock", clk_run, 1);
    slow_req = 1'b1;
    pulse(1);
    check("R4 override beats slow", share_reg[7:0], 50);
    slow_req = 1'b0;

    // R12 with override active: stored changes, applied stays forced
    write_freq(32'd25_000_000);
    check("R2 stored 25MHz", stored_div, exp_search(25_000_000));
    check("R12 forced apply", share_reg[7:0], 50);
    check("R12 forced run", clk_run, 1);
    check("R8 upper kept", share_reg[15:8], 8'hA5);

    // R11: bulk_ok and req_done together with idle clock off
    pulse(3);
    check("R11 same-cycle gate", clk_run, 0);
    pulse(1);
    check("R11 override cleared", share_reg[7:0], exp_apply(exp_search(25_000_000), 0, 0));

    // R5: slow scaling and its clamp
    slow_req = 1'b1;
    pulse(1);
    check("R5 slow x8", share_reg[7:0], exp_apply(1, 0, 1));
    pulse(2);
    check("R6 gate after done", clk_run, 0);
    write_freq(32'd200_000);
    check("R2 stored 200kHz", stored_div, exp_search(200_000));
    pulse(1);
    check("R5 slow clamp", share_reg[7:0], 255);
    slow_req = 1'b0;

    // R3: zero request
    sd = share_reg[7:0];
    write_freq(32'd0);
    check("R3 zero stored", stored_div, 255);
    check("R3 zero gates", clk_run, 0);
    check("R3 low byte kept", share_reg[7:0], sd);

    // R2: boundary requests
    write_freq(32'd50_000_000);
    check("R2 base rate", stored_div, 0);
    write_freq(32'd1);
    check("R2 tiny request", stored_div, 255);
    write_freq(32'd195_313);
    check("R2 near base/256", stored_div, exp_search(195_313));
    write_freq(32'd196_079);
    check("R2 just above", stored_div, exp_search(196_079));
    write_freq(32'hFFFF_FFFF);
    check("R2 huge request", stored_div, 0);

    // R9: waveform with divider 5, then stopped
    idle_clk_en = 1'b1;
    write_freq(32'd8_333_333);
    check("R12 idle run", clk_run, 1);
    repeat (600) @(negedge clk);
    measure(per, hi);
    check("R9 period d=5", per, 6);
    check("R9 high d=5", hi, 3);
    idle_clk_en = 1'b0;
    pulse(2);
    repeat (20) @(negedge clk);
    hi = 0;
    for (int k = 0; k < 20; k++) begin
      if (card_clk) hi++;
      @(negedge clk);
    end
    check("R9 stopped low", hi, 0);

    // R10: divider change in the middle of a period
    idle_clk_en = 1'b1;
    write_freq(32'd248_756);
    check("R2 stored 200", stored_div, 200);
    repeat (600) @(negedge clk);
    find_rise();
    hi = 0;
    freq_hz = 32'd8_333_333;
    for (int k = 0; k < 3000 && card_clk; k++) begin
      hi++;
      freq_wr = (k == 0);
      @(negedge clk);
    end
    freq_wr = 1'b0;
    check("R10 share updated", share_reg[7:0], 5);
    check("R10 old high phase", hi, 101);
    measure(per, hi);
    check("R10 new period", per, 6);

    // random mix: R2, R3, R6, R7, R12
    for (int it = 0; it < 20; it++) begin
      int r;
      @(negedge clk);
      idle_clk_en = $urandom % 2;
      slow_req    = $urandom % 2;
      r = $urandom % 4;
      case (r)
        0: f = ($urandom % 200_000) + 1;
        1: f = $urandom % 50_000_000;
        2: f = $urandom;
        default: f = 0;
      endcase
      prev_run = clk_run;
      sd = share_reg[7:0];
      write_freq(f);
      check("R2 random stored", stored_div, exp_search(f));
      if (f != 0) begin
        check("R12 random apply", share_reg[7:0], exp_apply(exp_search(f), 0, slow_req));
        check("R12 random run", clk_run, idle_clk_en);
      end else begin
        check("R3 random run", clk_run, idle_clk_en ? prev_run : 0);
        check("R3 random low kept", share_reg[7:0], sd);
      end
      pulse(1);
      check("R7 random start div", share_reg[7:0], exp_apply(exp_search(f), 0, slow_req));
      check("R7 random start run", clk_run, 1);
      pulse(2);
      check("R6 random done", clk_run, idle_clk_en);
    end

    finish_run();
  end

endmodule